// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register file of a multi-channel DMA controller. It holds up to 64 channels. It stores a global control word and several per-channel bitmaps: request enable, error-interrupt enable, interrupt flags, error flags and done bits. Each bitmap is exposed as two 32-bit words. The high word carries channels 63..32 and the low word carries channels 31..0. The block also keeps a decoded error status word, a rank byte for each channel, and a read-only view of the hardware request lines. Arbitration and the data path are outside this block. The arbitration and clock-gating bits are only stored here.

Software changes a single channel without a read-modify-write. It writes the channel number to one of eight byte-wide command addresses, and that one channel's bit is then set, cleared or pulsed. The transfer engines report completion and faults through per-channel event pulses. These pulses set sticky flags and raise a combined interrupt line. Flags are cleared either by command bytes or by writing ones to the flag words.

The bus is a plain single-cycle interface. A write is applied on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr` and need no strobe.

Top module: `dma_chan_csr`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every bitmap, the control word, the error status word, every rank byte, `start_pulse` and `irq`.
- R2: A write to the control word at 0x00 keeps only bit 31 (clock gating enable), bit 3 (round-robin group arbitration) and bit 2 (round-robin channel arbitration). Every other bit reads back as 0.
- R3: The request-enable bitmap is written and read as whole words, high word at 0x08 and low word at 0x0C. The error-interrupt-enable bitmap works the same way, high word at 0x10 and low word at 0x14. Channel c maps to bit c-32 of the high word, or to bit c of the low word.
- R4: A write of channel number N in `bus_wdata[7:0]` changes only bit N of one enable bitmap, from the next cycle on. The command addresses are: 0x18 sets request enable, 0x19 clears request enable, 0x1A sets error-interrupt enable and 0x1B clears error-interrupt enable.
- R5: Writing channel N to 0x1E raises bit N of `start_pulse` for exactly the one cycle after the write.
- R6: A `ch_done` pulse sets the channel's interrupt flag and its done bit. Writing N to 0x1C clears interrupt flag N. Writing N to 0x1F clears done bit N.
- R7: A `ch_err` pulse sets the channel's error flag. Writing N to 0x1D clears error flag N. The flags read as words at 0x28 (high) and 0x2C (low).
- R8: Writing ones to the interrupt flag words clears the matching flags. These words are 0x20 (high) and 0x24 (low). Writing ones to the error flag words at 0x28 and 0x2C does the same for error flags. Zero bits leave the flags unchanged.
- R9: An event arriving in the same cycle as a clear of the same flag wins, and the flag ends up set.
- R10: Every cycle that has an error event loads the error status word at 0x04. The fields are: bit 31 valid, bits 15:14 from `err_kind[9:8]`, bits 13:8 the channel, and bits 7:0 from `err_kind[7:0]`. When several channels fault at once, the highest-numbered channel is reported.
- R11: `irq` is high exactly while some interrupt flag is set, or some error flag is set together with its error-interrupt enable.
- R12: A command byte whose value is not below the channel count has no effect on any bitmap or on `start_pulse`.
- R13: Reads at 0x30 (high) and 0x34 (low) return `ch_hwreq`. Rank bytes are written and read as words from 0x100. Word k holds channels 4k..4k+3, with channel 4k in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data; command channel number in bits 7:0 |
| bus_rdata | output | 32 | Combinational read data |
| ch_done | input | NUM_CH | Per-channel completion pulses |
| ch_err | input | NUM_CH | Per-channel fault pulses |
| err_kind | input | 10 | Fault kind bits for the fault of this cycle |
| ch_hwreq | input | NUM_CH | Hardware request lines, readable only |
| start_pulse | output | NUM_CH | One-cycle start strobe per channel |
| req_en | output | NUM_CH | Request-enable bitmap |
| err_irq_en | output | NUM_CH | Error-interrupt-enable bitmap |
| done_bits | output | NUM_CH | Done bitmap |
| irq | output | 1 | Combined interrupt |

## Verification
Every register in this block is one flop stage from its cause. A write, a command byte or an event presented before a rising edge is visible on the bitmaps, on `start_pulse` and in the read data after that edge. `irq` follows in the same cycle, since it is a combination of those flops. Reads of `ch_hwreq` are purely combinational. The bench drives stimulus at the falling edge and advances its reference model by one step for the rising edge that follows. It then compares every output at the next falling edge, so every result is checked exactly one edge after its cause. Register readbacks are done between edges, one nanosecond after the address changes.

// File: rtl/dmacsr_pkg.sv
// Shared address map, command codes and widths for the DMA channel register file.
// Assumes a 9-bit byte address; the command block occupies eight consecutive bytes.
package dmacsr_pkg;
    localparam int ADDR_W  = 9;
    localparam int KIND_W  = 10;
    localparam int NUM_CMD = 8;

    localparam logic [ADDR_W-1:0] A_CTRL     = 9'h000;
    localparam logic [ADDR_W-1:0] A_ESTAT    = 9'h004;
    localparam logic [ADDR_W-1:0] A_REQ_HI   = 9'h008;
    localparam logic [ADDR_W-1:0] A_REQ_LO   = 9'h00C;
    localparam logic [ADDR_W-1:0] A_EIE_HI   = 9'h010;
    localparam logic [ADDR_W-1:0] A_EIE_LO   = 9'h014;
    localparam logic [ADDR_W-1:0] A_CMD_BASE = 9'h018;
    localparam logic [ADDR_W-1:0] A_INT_HI   = 9'h020;
    localparam logic [ADDR_W-1:0] A_INT_LO   = 9'h024;
    localparam logic [ADDR_W-1:0] A_ERR_HI   = 9'h028;
    localparam logic [ADDR_W-1:0] A_ERR_LO   = 9'h02C;
    localparam logic [ADDR_W-1:0] A_HWR_HI   = 9'h030;
    localparam logic [ADDR_W-1:0] A_HWR_LO   = 9'h034;

    localparam logic [31:0] CTRL_KEEP = 32'h8000_000C;

    // Command byte offset from A_CMD_BASE; the order is the decode of addr[2:0].
    typedef enum logic [2:0] {
        CMD_SET_REQ   = 3'd0,
        CMD_CLR_REQ   = 3'd1,
        CMD_SET_EIE   = 3'd2,
        CMD_CLR_EIE   = 3'd3,
        CMD_CLR_INT   = 3'd4,
        CMD_CLR_ERR   = 3'd5,
        CMD_SET_START = 3'd6,
        CMD_CLR_DONE  = 3'd7
    } cmd_e;
endpackage

// File: rtl/dmacsr_cmd_dec.sv
// Decodes a write into one of the eight command bytes into a one-hot channel
// vector per command. Assumes 2 <= NUM_CH <= 64; codes >= NUM_CH produce no hit.
module dmacsr_cmd_dec
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [7:0]                       code,
    output logic [NUM_CMD-1:0][NUM_CH-1:0]   hit
);
    localparam int         CH_W   = $clog2(NUM_CH);
    localparam logic [8:0] CH_LIM = 9'(NUM_CH);

    logic in_cmd;
    logic code_ok;

    assign in_cmd  = we && (addr[ADDR_W-1:3] == A_CMD_BASE[ADDR_W-1:3]);
    assign code_ok = ({1'b0, code} < CH_LIM);

    // One-hot select: command from the low address bits, channel from the data.
    always_comb begin
        hit = '0;
        if (in_cmd && code_ok)
            hit[addr[2:0]][code[CH_W-1:0]] = 1'b1;
    end
endmodule

// File: rtl/dmacsr_flagbank.sv
// One per-channel bitmap: optional whole-word load (high/low halves), then a
// clear mask, then a set mask. Set wins over clear and load in the same cycle.
// Assumes NUM_CH <= 64.
module dmacsr_flagbank #(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [31:0]       ld_word,
    input  logic [NUM_CH-1:0] set_v,
    input  logic [NUM_CH-1:0] clr_v,
    output logic [NUM_CH-1:0] q
);
    logic [63:0]       mask64;
    logic [63:0]       data64;
    logic [NUM_CH-1:0] ld_mask;
    logic [NUM_CH-1:0] ld_data;

    assign mask64  = {{32{ld_hi}}, {32{ld_lo}}};
    assign data64  = {ld_word, ld_word};
    assign ld_mask = mask64[NUM_CH-1:0];
    assign ld_data = data64[NUM_CH-1:0];

    // Bitmap update: load, clear, then set with highest precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= (((q & ~ld_mask) | (ld_data & ld_mask)) & ~clr_v) | set_v;
    end
endmodule

// File: rtl/dmacsr_errstat.sv
// Error status word: loaded on every cycle with a fault, reporting the
// highest-numbered faulting channel and the shared fault kind. Assumes NUM_CH <= 64.
module dmacsr_errstat
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_err,
    input  logic [KIND_W-1:0] kind,
    output logic [31:0]       status
);
    logic [5:0] top_ch;

    // Highest faulting channel: later loop iterations overwrite earlier ones.
    always_comb begin
        top_ch = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (ch_err[i]) top_ch = 6'(i);
    end

    // Status capture with the valid bit forced on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (|ch_err)
            status <= {1'b1, 15'd0, kind[9:8], top_ch, kind[7:0]};
    end
endmodule

// File: rtl/dma_chan_csr.sv
// Register file of a multi-channel DMA controller: control word, enable and
// flag bitmaps, command-byte channel updates, error status, rank bytes and the
// combined interrupt. Single-cycle write bus, combinational read.
// Assumes 4 <= NUM_CH <= 64 and NUM_CH a multiple of 4.
module dma_chan_csr
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_err,
    input  logic [KIND_W-1:0] err_kind,
    input  logic [NUM_CH-1:0] ch_hwreq,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] req_en,
    output logic [NUM_CH-1:0] err_irq_en,
    output logic [NUM_CH-1:0] done_bits,
    output logic              irq
);
    localparam int RANK_WORDS = NUM_CH / 4;

    logic [NUM_CMD-1:0][NUM_CH-1:0] cmd_hit;
    logic [NUM_CH-1:0]              int_q;
    logic [NUM_CH-1:0]              err_q;
    logic [31:0]                    ctrl_q;
    logic [31:0]                    err_status;
    logic [63:0]                    int_w1c;
    logic [63:0]                    err_w1c;
    logic [7:0]                     rank_q [NUM_CH];
    logic [31:0]                    rank_rd;
    logic                           rank_wr;
    logic [5:0]                     rank_idx;

    function automatic logic [63:0] ext64(input logic [NUM_CH-1:0] v);
        return 64'(v);
    endfunction

    dmacsr_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .we   (bus_we),
        .addr (bus_addr),
        .code (bus_wdata[7:0]),
        .hit  (cmd_hit)
    );

    assign int_w1c = {(bus_we && bus_addr == A_INT_HI) ? bus_wdata : 32'd0,
                      (bus_we && bus_addr == A_INT_LO) ? bus_wdata : 32'd0};
    assign err_w1c = {(bus_we && bus_addr == A_ERR_HI) ? bus_wdata : 32'd0,
                      (bus_we && bus_addr == A_ERR_LO) ? bus_wdata : 32'd0};

    dmacsr_flagbank #(.NUM_CH(NUM_CH)) u_req (
        .clk (clk), .rst_n (rst_n),
        .ld_hi (bus_we && bus_addr == A_REQ_HI), .ld_lo (bus_we && bus_addr == A_REQ_LO),
        .ld_word (bus_wdata),
        .set_v (cmd_hit[CMD_SET_REQ]), .clr_v (cmd_hit[CMD_CLR_REQ]),
        .q (req_en)
    );

    dmacsr_flagbank #(.NUM_CH(NUM_CH)) u_eie (
        .clk (clk), .rst_n (rst_n),
        .ld_hi (bus_we && bus_addr == A_EIE_HI), .ld_lo (bus_we && bus_addr == A_EIE_LO),
        .ld_word (bus_wdata),
        .set_v (cmd_hit[CMD_SET_EIE]), .clr_v (cmd_hit[CMD_CLR_EIE]),
        .q (err_irq_en)
    );

    dmacsr_flagbank #(.NUM_CH(NUM_CH)) u_int (
        .clk (clk), .rst_n (rst_n),
        .ld_hi (1'b0), .ld_lo (1'b0), .ld_word (32'd0),
        .set_v (ch_done), .clr_v (cmd_hit[CMD_CLR_INT] | int_w1c[NUM_CH-1:0]),
        .q (int_q)
    );

    dmacsr_flagbank #(.NUM_CH(NUM_CH)) u_err (
        .clk (clk), .rst_n (rst_n),
        .ld_hi (1'b0), .ld_lo (1'b0), .ld_word (32'd0),
        .set_v (ch_err), .clr_v (cmd_hit[CMD_CLR_ERR] | err_w1c[NUM_CH-1:0]),
        .q (err_q)
    );

    dmacsr_flagbank #(.NUM_CH(NUM_CH)) u_done (
        .clk (clk), .rst_n (rst_n),
        .ld_hi (1'b0), .ld_lo (1'b0), .ld_word (32'd0),
        .set_v (ch_done), .clr_v (cmd_hit[CMD_CLR_DONE]),
        .q (done_bits)
    );

    dmacsr_errstat #(.NUM_CH(NUM_CH)) u_estat (
        .clk (clk), .rst_n (rst_n),
        .ch_err (ch_err), .kind (err_kind),
        .status (err_status)
    );

    // Control word: only the gating and arbitration bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_we && bus_addr == A_CTRL)
            ctrl_q <= bus_wdata & CTRL_KEEP;
    end

    // Start strobes last exactly one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_pulse <= '0;
        else
            start_pulse <= cmd_hit[CMD_SET_START];
    end

    assign rank_wr  = bus_we && bus_addr[ADDR_W-1] && (bus_addr[1:0] == 2'b00);
    assign rank_idx = bus_addr[7:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rank
        // Rank byte c lives in word c/4, lane c%4.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rank_q[c] <= '0;
            else if (rank_wr && rank_idx == 6'(c / 4))
                rank_q[c] <= bus_wdata[(c % 4) * 8 +: 8];
        end
    end

    // Rank word readback assembled from four channel bytes.
    always_comb begin
        rank_rd = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (rank_idx == 6'(c / 4))
                rank_rd[(c % 4) * 8 +: 8] = rank_q[c];
    end

    // Combinational read mux over the byte address.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1]) begin
            if (bus_addr[1:0] == 2'b00 && rank_idx < 6'(RANK_WORDS))
                bus_rdata = rank_rd;
        end else begin
            case (bus_addr)
                A_CTRL:   bus_rdata = ctrl_q;
                A_ESTAT:  bus_rdata = err_status;
                A_REQ_HI: bus_rdata = ext64(req_en)[63:32];
                A_REQ_LO: bus_rdata = ext64(req_en)[31:0];
                A_EIE_HI: bus_rdata = ext64(err_irq_en)[63:32];
                A_EIE_LO: bus_rdata = ext64(err_irq_en)[31:0];
                A_INT_HI: bus_rdata = ext64(int_q)[63:32];
                A_INT_LO: bus_rdata = ext64(int_q)[31:0];
                A_ERR_HI: bus_rdata = ext64(err_q)[63:32];
                A_ERR_LO: bus_rdata = ext64(err_q)[31:0];
                A_HWR_HI: bus_rdata = ext64(ch_hwreq)[63:32];
                A_HWR_LO: bus_rdata = ext64(ch_hwreq)[31:0];
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Combined interrupt: any completion flag, or any enabled fault flag.
    assign irq = (|int_q) || (|(err_q & err_irq_en));
endmodule

// File: rtl/dma_chan_csr_chk.sv
// Temporal checks on the register file, attached to every instance by bind.
// Assumes the same NUM_CH as the bound instance.
module dma_chan_csr_chk
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        cmd_code,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_err,
    input logic [NUM_CH-1:0] start_pulse,
    input logic [NUM_CH-1:0] req_en,
    input logic [NUM_CH-1:0] done_bits,
    input logic              irq,
    input logic              err_valid
);
    localparam int         CH_W   = $clog2(NUM_CH);
    localparam logic [8:0] CH_LIM = 9'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_START = A_CMD_BASE + 9'(CMD_SET_START);

    logic is_cmd;
    logic code_ok;
    assign is_cmd  = bus_we && (bus_addr[ADDR_W-1:3] == A_CMD_BASE[ADDR_W-1:3]);
    assign code_ok = ({1'b0, cmd_code} < CH_LIM);

    p_start_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse));

    p_start_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse != '0) |-> ($past(bus_we) && $past(bus_addr) == A_START));

    p_setreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CMD_BASE && code_ok) |=> req_en[$past(cmd_code[CH_W-1:0])]);

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done != '0) |=> ((done_bits & $past(ch_done)) == $past(ch_done)));

    p_done_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done != '0) |=> irq);

    p_estat_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_err != '0) |=> err_valid);

    p_bad_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && !code_ok) |=> ($stable(req_en) && start_pulse == '0));
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .cmd_code    (bus_wdata[7:0]),
    .ch_done     (ch_done),
    .ch_err      (ch_err),
    .start_pulse (start_pulse),
    .req_en      (req_en),
    .done_bits   (done_bits),
    .irq         (irq),
    .err_valid   (err_status[31])
);

// File: tb/dma_chan_csr_bench.sv
module dma_chan_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] ch_done = '0;
    logic [63:0] ch_err = '0;
    logic [9:0]  err_kind = '0;
    logic [63:0] ch_hwreq = '0;
    logic [63:0] start_pulse, req_en, err_irq_en, done_bits;
    logic        irq;

    // Reference model state
    logic [63:0] m_req, m_eie, m_int, m_err, m_done, m_start;
    logic [31:0] m_ctrl, m_es;
    logic [7:0]  m_rank [64];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_chan_csr u_dma_chan_csr (
        .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .ch_done (ch_done),
        .ch_err (ch_err), .err_kind (err_kind), .ch_hwreq (ch_hwreq),
        .start_pulse (start_pulse), .req_en (req_en), .err_irq_en (err_irq_en),
        .done_bits (done_bits), .irq (irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_req = '0; m_eie = '0; m_int = '0; m_err = '0; m_done = '0; m_start = '0;
        m_ctrl = '0; m_es = '0;
        for (int i = 0; i < 64; i++) m_rank[i] = '0;
    endtask

    // One clock of the reference model: bus effects first, events last (events win).
    task automatic model_step();
        int c;
        bit ok;
        c  = int'(bus_wdata[7:0]);
        ok = (c < 64);
        m_start = '0;
        if (bus_we) begin
            if (bus_addr >= 9'h100) begin
                if (bus_addr[1:0] == 2'b00 && bus_addr[7:2] < 16)
                    for (int j = 0; j < 4; j++)
                        m_rank[bus_addr[7:2] * 4 + j] = bus_wdata[j*8 +: 8];
            end else if (bus_addr >= 9'h018 && bus_addr <= 9'h01F) begin
                if (ok) begin
                    case (bus_addr[2:0])
                        3'd0: m_req[c]   = 1'b1;
                        3'd1: m_req[c]   = 1'b0;
                        3'd2: m_eie[c]   = 1'b1;
                        3'd3: m_eie[c]   = 1'b0;
                        3'd4: m_int[c]   = 1'b0;
                        3'd5: m_err[c]   = 1'b0;
                        3'd6: m_start[c] = 1'b1;
                        default: m_done[c] = 1'b0;
                    endcase
                end
            end else begin
                case (bus_addr)
                    9'h000: m_ctrl = bus_wdata & 32'h8000_000C;
                    9'h008: m_req[63:32] = bus_wdata;
                    9'h00C: m_req[31:0]  = bus_wdata;
                    9'h010: m_eie[63:32] = bus_wdata;
                    9'h014: m_eie[31:0]  = bus_wdata;
                    9'h020: m_int[63:32] = m_int[63:32] & ~bus_wdata;
                    9'h024: m_int[31:0]  = m_int[31:0] & ~bus_wdata;
                    9'h028: m_err[63:32] = m_err[63:32] & ~bus_wdata;
                    9'h02C: m_err[31:0]  = m_err[31:0] & ~bus_wdata;
                    default: ;
                endcase
            end
        end
        m_int  = m_int | ch_done;
        m_done = m_done | ch_done;
        m_err  = m_err | ch_err;
        if (ch_err != '0) begin
            int hi = 0;
            for (int i = 0; i < 64; i++) if (ch_err[i]) hi = i;
            m_es = {1'b1, 15'd0, err_kind[9:8], 6'(hi), err_kind[7:0]};
        end
    endtask

    function automatic logic [31:0] m_read(input logic [8:0] a);
        if (a >= 9'h100) begin
            if (a[1:0] != 2'b00 || a[7:2] >= 16) return '0;
            return {m_rank[a[7:2]*4+3], m_rank[a[7:2]*4+2], m_rank[a[7:2]*4+1], m_rank[a[7:2]*4]};
        end
        case (a)
            9'h000: return m_ctrl;
            9'h004: return m_es;
            9'h008: return m_req[63:32];
            9'h00C: return m_req[31:0];
            9'h010: return m_eie[63:32];
            9'h014: return m_eie[31:0];
            9'h020: return m_int[63:32];
            9'h024: return m_int[31:0];
            9'h028: return m_err[63:32];
            9'h02C: return m_err[31:0];
            9'h030: return ch_hwreq[63:32];
            9'h034: return ch_hwreq[31:0];
            default: return '0;
        endcase
    endfunction

    // Advance one clock and compare all outputs at the following falling edge.
    task automatic tick();
        if (rst_n) model_step(); else model_reset();
        @(posedge clk);
        @(negedge clk);
        chk("R4 req_en", req_en, m_req);
        chk("R4 err_irq_en", err_irq_en, m_eie);
        chk("R6 done_bits", done_bits, m_done);
        chk("R5 start_pulse", start_pulse, m_start);
        chk("R11 irq", {63'd0, irq}, {63'd0, (|m_int) || (|(m_err & m_eie))});
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] k, input logic [7:0] ch);
        wr(9'h018 + 9'(k), {24'd0, ch});
    endtask

    task automatic rd(input logic [8:0] a, input string tag);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, {32'd0, bus_rdata}, {32'd0, m_read(a)});
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a <= 'h34; a += 4) rd(9'(a), tag);
        for (int a = 'h100; a < 'h140; a += 4) rd(9'(a), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: everything reads zero after reset
        rd_all("R1 reset readback");
        chk("R1 irq after reset", {63'd0, irq}, 64'd0);

        // R2: only three control bits kept
        wr(9'h000, 32'hFFFF_FFFF);
        rd(9'h000, "R2 ctrl");
        chk("R2 ctrl literal", {32'd0, bus_rdata}, 64'h8000_000C);
        wr(9'h000, 32'h7FFF_FFF3);
        rd(9'h000, "R2 ctrl zero");

        // R3: whole-word enables, high word carries channels 63..32
        wr(9'h008, 32'hA5A5_0001);
        wr(9'h00C, 32'h8000_0003);
        wr(9'h010, 32'h0000_0100);
        wr(9'h014, 32'h0000_0000);
        rd(9'h008, "R3 req hi"); rd(9'h00C, "R3 req lo");
        rd(9'h010, "R3 eie hi"); rd(9'h014, "R3 eie lo");
        chk("R3 ch32 bit", {63'd0, req_en[32]}, 64'd1);

        // R4: single-channel commands
        cmd(3'd0, 8'd5);  cmd(3'd0, 8'd40); cmd(3'd1, 8'd0);
        cmd(3'd2, 8'd63); cmd(3'd3, 8'd40); cmd(3'd1, 8'd63);
        rd(9'h00C, "R4 req lo after cmds"); rd(9'h010, "R4 eie hi after cmds");
        chk("R4 ch5 literal", {63'd0, req_en[5]}, 64'd1);

        // R5: start strobe for one cycle only
        cmd(3'd6, 8'd7);
        chk("R5 start ch7", start_pulse, 64'h80);
        tick();
        chk("R5 start gone", start_pulse, 64'd0);

        // R6: completion sets interrupt and done, each cleared by its own command
        ch_done = (64'd1 << 3) | (64'd1 << 50); tick(); ch_done = '0;
        rd(9'h024, "R6 int lo"); rd(9'h020, "R6 int hi");
        chk("R11 irq on done", {63'd0, irq}, 64'd1);
        cmd(3'd4, 8'd3); rd(9'h024, "R6 int cleared");
        cmd(3'd7, 8'd50); chk("R6 done50 cleared", {63'd0, done_bits[50]}, 64'd0);

        // R8: write-one-to-clear interrupt flags
        wr(9'h020, 32'h0004_0000); rd(9'h020, "R8 int hi w1c");
        chk("R11 irq low", {63'd0, irq}, 64'd0);

        // R7 and R11: fault flag, masked then enabled
        wr(9'h010, 32'h0); wr(9'h014, 32'h0);
        ch_err = 64'd1 << 10; err_kind = 10'h081; tick(); ch_err = '0;
        rd(9'h02C, "R7 err lo");
        chk("R11 masked fault", {63'd0, irq}, 64'd0);
        cmd(3'd2, 8'd10);
        chk("R11 enabled fault", {63'd0, irq}, 64'd1);
        cmd(3'd5, 8'd10); rd(9'h02C, "R7 err cleared");
        ch_err = (64'd1 << 44) | 64'd1; tick(); ch_err = '0;
        wr(9'h028, 32'h0000_1000); rd(9'h028, "R8 err hi w1c");
        wr(9'h02C, 32'h0000_0000); rd(9'h02C, "R8 zero keeps");
        wr(9'h02C, 32'h0000_0001); rd(9'h02C, "R8 err lo w1c");

        // R9: same-cycle event beats clear
        ch_done = 64'd1 << 9; cmd(3'd4, 8'd9); ch_done = '0;
        rd(9'h024, "R9 int kept");
        ch_err = 64'd1 << 33; wr(9'h028, 32'h0000_0002); ch_err = '0;
        rd(9'h028, "R9 err kept");
        ch_done = 64'd1 << 12; cmd(3'd7, 8'd12); ch_done = '0;
        chk("R9 done kept", {63'd0, done_bits[12]}, 64'd1);

        // R10: highest faulting channel and kind fields
        ch_err = (64'd1 << 2) | (64'd1 << 33); err_kind = 10'h3A5; tick(); ch_err = '0;
        rd(9'h004, "R10 estat");
        chk("R10 estat literal", {32'd0, bus_rdata}, {32'd0, 32'h8000_E1A5});

        // R12: out-of-range command codes do nothing
        wr(9'h00C, 32'h0); wr(9'h008, 32'h0);
        cmd(3'd0, 8'd64); cmd(3'd0, 8'd200); cmd(3'd6, 8'd255); cmd(3'd2, 8'd64);
        rd(9'h00C, "R12 req lo"); rd(9'h008, "R12 req hi"); rd(9'h010, "R12 eie hi");
        chk("R12 start none", start_pulse, 64'd0);

        // R13: hardware request view and rank bytes
        ch_hwreq = 64'h1234_5678_9ABC_DEF0;
        rd(9'h030, "R13 hwreq hi"); rd(9'h034, "R13 hwreq lo");
        wr(9'h100, 32'h4433_2211); wr(9'h13C, 32'hDDCC_BBAA);
        rd(9'h100, "R13 rank w0"); rd(9'h13C, "R13 rank w15");
        chk("R13 rank literal", {32'd0, bus_rdata}, 64'hDDCC_BBAA);

        // Mixed traffic against the model
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 6);
            ch_hwreq = {$urandom, $urandom};
            if (($urandom % 3) == 0) ch_done = 64'd1 << ($urandom % 64);
            if (($urandom % 4) == 0) begin
                ch_err = 64'd1 << ($urandom % 64);
                err_kind = 10'($urandom);
            end
            case (op)
                0: cmd(3'($urandom), 8'($urandom % 72));
                1: wr(9'(4 * ($urandom % 14)), $urandom);
                2: wr(9'h100 + 9'(4 * ($urandom % 16)), $urandom);
                3: wr(9'h020 + 9'(4 * ($urandom % 4)), $urandom);
                default: tick();
            endcase
            ch_done = '0; ch_err = '0;
            if ((it % 16) == 15) rd_all("R13 mixed readback");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule